// File: doc/BRIEF.md
# Operand Address Generator with Paged and Register-Pointer Modes

This block produces the 16-bit data memory address for every operand access. It has two modes. In paged mode, a 7-bit offset taken from the instruction word is joined below a 9-bit page register. This divides the data space into 512 pages of 128 words each. In register-pointer mode, the address is the contents of one of eight 16-bit address registers, chosen by a 3-bit selector register.

The page register, the eight address registers and the selector each have a load port. A register-pointer access can also ask for its selected register to be stepped up or down by one once the address has been issued. That lets a loop walk through a buffer without spending extra instructions on pointer updates. The address output is combinational from the current register state and the mode and offset inputs. Every register change becomes visible on the next cycle.

Top module: `data_addr_gen`

## Requirements
- R1: While reset is asserted and after its release, the page register, the selector and all eight address registers are zero, so `addr_out` is 0 in register-pointer mode and in paged mode with a zero offset.
- R2: With `mode_ind`=0, `addr_out[15:7]` equals the page register and `addr_out[6:0]` equals `ofs_in`, whether or not `acc_en` is high.
- R3: A page load (`page_ld`=1) stores `page_din`, and the new page appears on `addr_out` from the following cycle onward.
- R4: With `mode_ind`=1, `addr_out` equals the address register whose index is held in the selector.
- R5: A register load (`ar_ld`=1) writes `ar_din` into the register indexed by `ar_ld_idx`, and the value is visible from the next cycle.
- R6: A selector load (`arp_ld`=1) that coincides with a register-pointer access leaves that access on the old selection. The new selection applies from the next cycle.
- R7: A register-pointer access (`acc_en`=1, `mode_ind`=1) with `upd_op`=2'b01 leaves the selected register one higher on the next cycle, wrapping 0xFFFF to 0x0000.
- R8: The same access with `upd_op`=2'b10 leaves the selected register one lower, wrapping 0x0000 to 0xFFFF.
- R9: `upd_op`=2'b00 or 2'b11, `acc_en`=0, or paged mode leaves every address register unchanged.
- R10: When an explicit register load targets the same register that a post-modify would change in that cycle, the loaded value is stored.
- R11: A post-modify changes only the selected register. The other seven keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_ind | input | 1 | 1 = register-pointer mode, 0 = paged mode |
| ofs_in | input | 7 | Offset field from the instruction word |
| acc_en | input | 1 | An operand access takes place this cycle |
| upd_op | input | 2 | Post-modify: 01 step up, 10 step down, 00/11 none |
| page_ld | input | 1 | Load the page register |
| page_din | input | 9 | New page value |
| ar_ld | input | 1 | Load one address register |
| ar_ld_idx | input | 3 | Index of the register to load |
| ar_din | input | 16 | New address register value |
| arp_ld | input | 1 | Load the selector |
| arp_din | input | 3 | New selector value |
| addr_out | output | 16 | Operand data address |

## Verification
The hardest case to reach is a single cycle in which three things happen together: a register-pointer access that post-modifies, a selector reload, and an explicit load aimed at the register the access uses. In that cycle the old selection, the new selection and the load priority all decide the outcome. The directed phase builds this cycle on purpose and also drives step-up and step-down across the 0xFFFF/0x0000 boundary. The random phase keeps indices to eight values and biases load data toward the boundary values, so collisions and wraps recur. Every register is read back through register-pointer mode with `acc_en` low, which does not disturb the state being observed.

// File: rtl/data_addr_gen.sv
module data_addr_gen #(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 7,
  parameter int NUM_AR = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        mode_ind,
  input  logic [OFS_W-1:0]            ofs_in,
  input  logic                        acc_en,
  input  logic [1:0]                  upd_op,
  input  logic                        page_ld,
  input  logic [ADDR_W-OFS_W-1:0]     page_din,
  input  logic                        ar_ld,
  input  logic [$clog2(NUM_AR)-1:0]   ar_ld_idx,
  input  logic [ADDR_W-1:0]           ar_din,
  input  logic                        arp_ld,
  input  logic [$clog2(NUM_AR)-1:0]   arp_din,
  output logic [ADDR_W-1:0]           addr_out
);
  localparam int PAGE_W = ADDR_W - OFS_W;
  localparam int SEL_W  = $clog2(NUM_AR);
  localparam logic [1:0] UPD_INC = 2'b01;
  localparam logic [1:0] UPD_DEC = 2'b10;

  logic [PAGE_W-1:0]              page_q;
  logic [SEL_W-1:0]               arp_q;
  logic [NUM_AR-1:0][ADDR_W-1:0]  ar_q;
  logic [ADDR_W-1:0]              cur_ar, mod_val;
  logic                           mod_en;

  assign cur_ar   = ar_q[arp_q];
  assign addr_out = mode_ind ? cur_ar : {page_q, ofs_in};
  assign mod_en   = acc_en && mode_ind && (upd_op == UPD_INC || upd_op == UPD_DEC);
  assign mod_val  = (upd_op == UPD_INC) ? cur_ar + ADDR_W'(1) : cur_ar - ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q <= '0;
      arp_q  <= '0;
    end else begin
      if (page_ld) page_q <= page_din;
      if (arp_ld)  arp_q  <= arp_din;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ar_q <= '0;
    end else begin
      for (int i = 0; i < NUM_AR; i++) begin
        if (ar_ld && ar_ld_idx == SEL_W'(i))
          ar_q[i] <= ar_din;
        else if (mod_en && arp_q == SEL_W'(i))
          ar_q[i] <= mod_val;
      end
    end
  end

  a_r3_page_load: assert property (@(posedge clk) disable iff (!rst_n)
    page_ld |=> page_q == $past(page_din));

  a_r5_ar_load: assert property (@(posedge clk) disable iff (!rst_n)
    ar_ld |=> ar_q[$past(ar_ld_idx)] == $past(ar_din));

  a_r6_arp_next: assert property (@(posedge clk) disable iff (!rst_n)
    arp_ld |=> arp_q == $past(arp_din));

  a_r7_post_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && mode_ind && upd_op == UPD_INC && !(ar_ld && ar_ld_idx == arp_q))
    |=> ar_q[$past(arp_q)] == ADDR_W'($past(addr_out) + ADDR_W'(1)));

  a_r8_post_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && mode_ind && upd_op == UPD_DEC && !(ar_ld && ar_ld_idx == arp_q))
    |=> ar_q[$past(arp_q)] == ADDR_W'($past(addr_out) - ADDR_W'(1)));

  a_r9_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (!ar_ld && !(acc_en && mode_ind && (upd_op == UPD_INC || upd_op == UPD_DEC)))
    |=> $stable(ar_q));
endmodule

// File: tb/data_addr_gen_tb.sv
module data_addr_gen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        mode_ind = 0;
  logic [6:0]  ofs_in = 0;
  logic        acc_en = 0;
  logic [1:0]  upd_op = 0;
  logic        page_ld = 0;
  logic [8:0]  page_din = 0;
  logic        ar_ld = 0;
  logic [2:0]  ar_ld_idx = 0;
  logic [15:0] ar_din = 0;
  logic        arp_ld = 0;
  logic [2:0]  arp_din = 0;
  logic [15:0] addr_out;

  int errors = 0;
  int checks = 0;

  logic [15:0] m_ar [8];
  logic [8:0]  m_page;
  logic [2:0]  m_arp;

  always #(CLK_PERIOD/2) clk = ~clk;

  data_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .mode_ind(mode_ind), .ofs_in(ofs_in),
    .acc_en(acc_en), .upd_op(upd_op), .page_ld(page_ld), .page_din(page_din),
    .ar_ld(ar_ld), .ar_ld_idx(ar_ld_idx), .ar_din(ar_din),
    .arp_ld(arp_ld), .arp_din(arp_din), .addr_out(addr_out)
  );

  function automatic logic [15:0] exp_addr(input logic m, input logic [6:0] o);
    return m ? m_ar[m_arp] : {m_page, o};
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: addr_out=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 8; i++) m_ar[i] = '0;
    m_page = '0;
    m_arp  = '0;
  endtask

  task automatic model_step();
    logic [2:0] old_arp;
    old_arp = m_arp;
    if (page_ld) m_page = page_din;
    if (arp_ld)  m_arp  = arp_din;
    if (acc_en && mode_ind && upd_op == 2'b01) m_ar[old_arp] = m_ar[old_arp] + 16'd1;
    if (acc_en && mode_ind && upd_op == 2'b10) m_ar[old_arp] = m_ar[old_arp] - 16'd1;
    if (ar_ld) m_ar[ar_ld_idx] = ar_din;
  endtask

  task automatic idle();
    acc_en = 0; upd_op = 0; page_ld = 0; ar_ld = 0; arp_ld = 0;
  endtask

  // Drive at falling edge, check combinational address, commit at rising edge.
  task automatic cyc(input string tag);
    #1;
    check(tag, addr_out, exp_addr(mode_ind, ofs_in));
    @(posedge clk);
    model_step();
    @(negedge clk);
    idle();
  endtask

  task automatic read_ar(input string tag, input logic [2:0] idx);
    arp_ld = 1; arp_din = idx; mode_ind = 1;
    cyc(tag);
    mode_ind = 1;
    cyc(tag);
  endtask

  task automatic load_ar(input logic [2:0] idx, input logic [15:0] v);
    ar_ld = 1; ar_ld_idx = idx; ar_din = v;
    cyc("R5");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: addr_out=%h expected=done", addr_out);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    model_reset();
    @(negedge clk);
    mode_ind = 1; #1; check("R1", addr_out, 16'h0000);
    mode_ind = 0; ofs_in = 0; #1; check("R1", addr_out, 16'h0000);
    @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 8; i++) read_ar("R1", 3'(i));

    // R2/R3 paged mode, page load seen next cycle
    mode_ind = 0; ofs_in = 7'h7F; page_ld = 1; page_din = 9'h1A5; acc_en = 1;
    cyc("R3");
    mode_ind = 0; ofs_in = 7'h7F; cyc("R3");
    check("R3", addr_out, {9'h1A5, 7'h7F});
    mode_ind = 0; ofs_in = 7'h00; acc_en = 1; upd_op = 2'b01; cyc("R2");

    // R4/R5
    for (int i = 0; i < 8; i++) load_ar(3'(i), 16'h1000 + 16'(i * 16'h111));
    for (int i = 0; i < 8; i++) read_ar("R4", 3'(i));

    // R6: selector reload during access
    arp_ld = 1; arp_din = 3; mode_ind = 1; cyc("R6");
    mode_ind = 1; arp_ld = 1; arp_din = 6; acc_en = 1; cyc("R6");
    mode_ind = 1; #1; check("R6", addr_out, m_ar[6]);
    cyc("R6");

    // R7 wrap up
    load_ar(2, 16'hFFFF);
    arp_ld = 1; arp_din = 2; cyc("R7");
    mode_ind = 1; acc_en = 1; upd_op = 2'b01; cyc("R7");
    mode_ind = 1; #1; check("R7", addr_out, 16'h0000);
    acc_en = 1; upd_op = 2'b01; cyc("R7");
    mode_ind = 1; #1; check("R7", addr_out, 16'h0001);

    // R8 wrap down
    load_ar(5, 16'h0000);
    arp_ld = 1; arp_din = 5; cyc("R8");
    mode_ind = 1; acc_en = 1; upd_op = 2'b10; cyc("R8");
    mode_ind = 1; #1; check("R8", addr_out, 16'hFFFF);

    // R9: no-op codes, acc_en low, paged mode
    mode_ind = 1; acc_en = 1; upd_op = 2'b11; cyc("R9");
    mode_ind = 1; acc_en = 1; upd_op = 2'b00; cyc("R9");
    mode_ind = 1; acc_en = 0; upd_op = 2'b01; cyc("R9");
    mode_ind = 0; acc_en = 1; upd_op = 2'b10; cyc("R9");
    mode_ind = 1; #1; check("R9", addr_out, 16'hFFFF);

    // R10: load collides with post-modify, selector reload same cycle
    mode_ind = 1; acc_en = 1; upd_op = 2'b01; ar_ld = 1; ar_ld_idx = 5; ar_din = 16'hBEEF;
    arp_ld = 1; arp_din = 0; cyc("R10");
    read_ar("R10", 5);
    check("R10", addr_out, 16'hBEEF);

    // R11: only selected register changes
    for (int i = 0; i < 8; i++) load_ar(3'(i), 16'h4000 + 16'(i));
    arp_ld = 1; arp_din = 4; cyc("R11");
    mode_ind = 1; acc_en = 1; upd_op = 2'b01; cyc("R11");
    for (int i = 0; i < 8; i++) begin
      read_ar("R11", 3'(i));
      check("R11", addr_out, 16'h4000 + 16'(i) + ((i == 4) ? 16'd1 : 16'd0));
    end

    // Random phase
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] pick;
      mode_ind = 1'($urandom);
      ofs_in   = 7'($urandom);
      acc_en   = 1'($urandom);
      upd_op   = 2'($urandom);
      page_ld  = ($urandom % 5) == 0;
      page_din = 9'($urandom);
      ar_ld    = ($urandom % 3) == 0;
      ar_ld_idx = 3'($urandom);
      pick = 3'($urandom);
      ar_din   = (pick == 0) ? 16'hFFFF : (pick == 1) ? 16'h0000 : 16'($urandom);
      arp_ld   = ($urandom % 3) == 0;
      arp_din  = 3'($urandom);
      cyc(mode_ind ? "R4" : "R2");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule